// File: doc/BRIEF.md
# Exception Status and Control Register Unit

This unit holds the system-control registers of a small scalar processor core. Two of its registers have special behaviour: a Status register that carries a three-level stack of mode/interrupt-enable pairs in its low six bits, and a Cause register that records why the last exception was taken. The remaining register slots are plain storage, one of which also receives the exception return address (EPC). The core reads any slot through a combinational read port and writes through a single write port.

On a system-call or breakpoint request, or when a software interrupt is pending and enabled, the unit enters an exception in one clock edge. It pushes the mode/enable stack, writes an exception code and the delay-slot flag into Cause, captures the return address, and pulses `exc_taken` for one cycle. A return-from-exception strobe pops the stack. Status bit 22 selects which of two handler addresses appears on `vector_addr`.

Top module: `sysctl_exc_unit`

## Requirements
- R1: After reset every register slot reads 0, `exc_taken` is 0 and `vector_addr` equals the low vector (0x8000_0080).
- R2: A write to any index other than 13 stores the data unchanged in that slot, including Status at index 12 and EPC at index 14. Read data for `rd_idx` reflects it after the write edge.
- R3: A write to Cause (index 13) changes only Cause bits 9..8. No other Cause bit changes except through exception entry.
- R4: A system call loads the Cause code field (bits 6..2) with 8 (Cause value 0x20). A breakpoint loads it with 9 (0x24). `exc_taken` is high for exactly the one cycle after each entry edge.
- R5: On exception entry, Status bits 5..2 take the old bits 3..0, bits 1..0 become 0, and bits 31..6 are unchanged.
- R6: On entry with `in_delay` set, Cause bit 31 becomes 1 and EPC becomes `exc_pc` minus 4. Otherwise Cause bit 31 becomes 0 and EPC becomes `exc_pc`.
- R7: A return-from-exception strobe sets Status bits 3..0 to the old bits 5..2 and leaves bits 31..4 unchanged.
- R8: A software interrupt is entered when (Cause & Status & 0x300) is nonzero and Status bit 0 is 1. Its entry clears the Cause code field to 0, and it is taken only once because the push clears Status bit 0.
- R9: Entry priority is system call, then breakpoint, then software interrupt. In an entry cycle, a register write and a return-from-exception strobe are both discarded.
- R10: `vector_addr` is 0xBFC0_0180 when Status bit 22 is 1 and 0x8000_0080 when it is 0.
- R11: When a Status write and a return-from-exception strobe fall in the same cycle, without an entry, the written value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 5 | Register write index |
| wr_data | input | 32 | Register write data |
| rd_idx | input | 5 | Register read index |
| rd_data | output | 32 | Read data for `rd_idx` |
| sys_req | input | 1 | System-call exception request |
| brk_req | input | 1 | Breakpoint exception request |
| exc_pc | input | 32 | Address of the instruction raising the request |
| in_delay | input | 1 | Requesting instruction sits in a branch delay slot |
| rfe | input | 1 | Return-from-exception strobe |
| exc_taken | output | 1 | One-cycle pulse after an exception entry |
| epc | output | 32 | Captured exception return address |
| vector_addr | output | 32 | Handler address selected by Status bit 22 |

## Verification
The case that needs the most care is an exception entry landing in the same cycle as a stack pop or a register write, because both touch Status. The bench provokes this by raising a system-call request together with `rfe`, and together with a write to a plain slot. It then reads Status and that slot back, and expects the pushed Status and the untouched slot. It also raises `rfe` together with a Status write, and breakpoint and system-call requests together with a pending software interrupt. Each result is judged against the priority order stated in the requirements.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int CODE_W = 5;

    typedef enum logic [1:0] {
        EXC_NONE = 2'd0,
        EXC_SYS  = 2'd1,
        EXC_BRK  = 2'd2,
        EXC_SWI  = 2'd3
    } exc_kind_e;

    // code field value per exception kind
    function automatic logic [CODE_W-1:0] exc_code(input exc_kind_e kind);
        case (kind)
            EXC_SYS: return CODE_W'(8);
            EXC_BRK: return CODE_W'(9);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_swi_detect.sv
module sysctl_swi_detect #(
    parameter int SWI_N = 2
) (
    input  logic [SWI_N-1:0] status_mask,
    input  logic [SWI_N-1:0] cause_req,
    input  logic             ie_cur,
    output logic             pending
);
    always_comb begin
        pending = (|(status_mask & cause_req)) & ie_cur;
    end
endmodule

// File: rtl/sysctl_exc_arbiter.sv
module sysctl_exc_arbiter
    import sysctl_pkg::*;
(
    input  logic      sys_req,
    input  logic      brk_req,
    input  logic      swi_pending,
    output exc_kind_e kind
);
    always_comb begin
        if (sys_req)          kind = EXC_SYS;
        else if (brk_req)     kind = EXC_BRK;
        else if (swi_pending) kind = EXC_SWI;
        else                  kind = EXC_NONE;
    end
endmodule

// File: rtl/sysctl_mode_stack.sv
module sysctl_mode_stack #(
    parameter int DW     = 32,
    parameter int LEVELS = 3,
    parameter int LW     = 2
) (
    input  logic [DW-1:0] status,
    output logic [DW-1:0] pushed,
    output logic [DW-1:0] popped
);
    localparam int STK_W = LEVELS * LW;

    assign pushed[DW-1:STK_W] = status[DW-1:STK_W];
    assign popped[DW-1:STK_W] = status[DW-1:STK_W];

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        if (g == 0) begin : g_bottom
            assign pushed[g*LW +: LW] = '0;
        end else begin : g_shift_up
            assign pushed[g*LW +: LW] = status[(g-1)*LW +: LW];
        end
        if (g == LEVELS - 1) begin : g_top
            assign popped[g*LW +: LW] = status[g*LW +: LW];
        end else begin : g_shift_down
            assign popped[g*LW +: LW] = status[(g+1)*LW +: LW];
        end
    end
endmodule

// File: rtl/sysctl_exc_unit.sv
module sysctl_exc_unit
    import sysctl_pkg::*;
#(
    parameter int          DW         = 32,
    parameter int          IDX_W      = 5,
    parameter int          STATUS_IDX = 12,
    parameter int          CAUSE_IDX  = 13,
    parameter int          EPC_IDX    = 14,
    parameter int          BEV_BIT    = 22,
    parameter int          SWI_LSB    = 8,
    parameter int          SWI_N      = 2,
    parameter int          STK_LEVELS = 3,
    parameter int          STK_LW     = 2,
    parameter logic [31:0] VEC_LO     = 32'h8000_0080,
    parameter logic [31:0] VEC_HI     = 32'hBFC0_0180
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_data,
    input  logic             sys_req,
    input  logic             brk_req,
    input  logic [DW-1:0]    exc_pc,
    input  logic             in_delay,
    input  logic             rfe,
    output logic             exc_taken,
    output logic [DW-1:0]    epc,
    output logic [DW-1:0]    vector_addr
);
    localparam int            NREGS      = 1 << IDX_W;
    localparam int            CODE_LSB   = 2;
    localparam int            BD_BIT     = DW - 1;
    localparam logic [DW-1:0] PC_STEP    = DW'(4);
    localparam logic [DW-1:0] CAUSE_WMSK = DW'(((1 << SWI_N) - 1) << SWI_LSB);
    localparam logic [DW-1:0] CODE_MSK   = DW'(((1 << CODE_W) - 1) << CODE_LSB);

    typedef struct packed {
        logic [NREGS-1:0][DW-1:0] regs;
        logic                     taken;
    } state_t;

    state_t st_q, st_d;

    logic [DW-1:0] status_q, cause_q, epc_q;
    logic [DW-1:0] status_push, status_pop;
    logic [DW-1:0] cause_entry, epc_entry, cause_wr;
    logic          swi_pending;
    exc_kind_e     kind;

    assign status_q = st_q.regs[STATUS_IDX];
    assign cause_q  = st_q.regs[CAUSE_IDX];
    assign epc_q    = st_q.regs[EPC_IDX];

    sysctl_swi_detect #(.SWI_N(SWI_N)) u_swi (
        .status_mask (status_q[SWI_LSB +: SWI_N]),
        .cause_req   (cause_q[SWI_LSB +: SWI_N]),
        .ie_cur      (status_q[0]),
        .pending     (swi_pending)
    );

    sysctl_exc_arbiter u_arb (
        .sys_req     (sys_req),
        .brk_req     (brk_req),
        .swi_pending (swi_pending),
        .kind        (kind)
    );

    sysctl_mode_stack #(.DW(DW), .LEVELS(STK_LEVELS), .LW(STK_LW)) u_stack (
        .status (status_q),
        .pushed (status_push),
        .popped (status_pop)
    );

    // values written on an entry edge and on a Cause write
    always_comb begin
        cause_entry         = (cause_q & ~CODE_MSK) | (DW'(exc_code(kind)) << CODE_LSB);
        cause_entry[BD_BIT] = in_delay;
        epc_entry           = in_delay ? (exc_pc - PC_STEP) : exc_pc;
        cause_wr            = (cause_q & ~CAUSE_WMSK) | (wr_data & CAUSE_WMSK);
    end

    always_comb begin
        st_d       = st_q;
        st_d.taken = 1'b0;
        if (kind != EXC_NONE) begin
            st_d.taken                = 1'b1;
            st_d.regs[STATUS_IDX]     = status_push;
            st_d.regs[CAUSE_IDX]      = cause_entry;
            st_d.regs[EPC_IDX]        = epc_entry;
        end else begin
            if (rfe) begin
                st_d.regs[STATUS_IDX] = status_pop;
            end
            if (wr_en) begin
                if (wr_idx == IDX_W'(CAUSE_IDX)) begin
                    st_d.regs[CAUSE_IDX] = cause_wr;
                end else begin
                    st_d.regs[wr_idx] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data     = st_q.regs[rd_idx];
    assign exc_taken   = st_q.taken;
    assign epc         = epc_q;
    assign vector_addr = status_q[BEV_BIT] ? DW'(VEC_HI) : DW'(VEC_LO);

endmodule

// File: rtl/sysctl_exc_chk.sv
module sysctl_exc_chk #(
    parameter int DW         = 32,
    parameter int IDX_W      = 5,
    parameter int STATUS_IDX = 12,
    parameter int SWI_LSB    = 8,
    parameter int SWI_N      = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic             sys_req,
    input logic             brk_req,
    input logic [DW-1:0]    exc_pc,
    input logic             in_delay,
    input logic             rfe,
    input logic             exc_taken,
    input logic [DW-1:0]    status,
    input logic [DW-1:0]    cause,
    input logic [DW-1:0]    epc
);
    logic swp;
    assign swp = (|(status[SWI_LSB +: SWI_N] & cause[SWI_LSB +: SWI_N])) && status[0];

    // R4: a system call is recorded with code 8 and a taken pulse
    a_r4_sys_entry: assert property (@(posedge clk) disable iff (!rst_n)
        sys_req |=> (exc_taken && cause[6:2] == 5'd8));

    // R5: entry pushes the mode/enable stack
    a_r5_stack_push: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |-> (status[1:0] == 2'b00 && status[5:2] == $past(status[3:0])
                       && status[DW-1:6] == $past(status[DW-1:6])));

    // R6: delay-slot entry backs EPC up by one instruction
    a_r6_delay_epc: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_req && in_delay) |=> (epc == $past(exc_pc) - DW'(4) && cause[DW-1]));

    // R3: Cause bits outside the written, code and delay fields never move
    a_r3_cause_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cause[DW-2:10]) && $stable(cause[7]) && $stable(cause[1:0]));

    // R7: a lone return strobe pops the stack
    a_r7_rfe_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (rfe && !sys_req && !brk_req && !swp && !(wr_en && wr_idx == IDX_W'(STATUS_IDX)))
        |=> (status[3:0] == $past(status[5:2]) && status[DW-1:4] == $past(status[DW-1:4])));

    // R8: an enabled pending software interrupt is entered with code 0
    a_r8_swi_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (swp && !sys_req && !brk_req) |=> (exc_taken && cause[6:2] == 5'd0));

    // R9: breakpoint beats a pending software interrupt
    a_r9_brk_over_swi: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_req && !sys_req) |=> cause[6:2] == 5'd9);
endmodule

bind sysctl_exc_unit sysctl_exc_chk #(
    .DW(DW), .IDX_W(IDX_W), .STATUS_IDX(STATUS_IDX), .SWI_LSB(SWI_LSB), .SWI_N(SWI_N)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .sys_req   (sys_req),
    .brk_req   (brk_req),
    .exc_pc    (exc_pc),
    .in_delay  (in_delay),
    .rfe       (rfe),
    .exc_taken (exc_taken),
    .status    (status_q),
    .cause     (cause_q),
    .epc       (epc_q)
);

// File: tb/sysctl_exc_unit_test.sv
`timescale 1ns/1ps
module sysctl_exc_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        sys_req = 1'b0, brk_req = 1'b0, in_delay = 1'b0, rfe = 1'b0;
    logic [31:0] exc_pc = '0;
    logic        exc_taken;
    logic [31:0] epc, vector_addr;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    logic [31:0] m_reg [32];
    logic [31:0] m_st, m_ca, m_epc;

    always #5 clk = ~clk;

    sysctl_exc_unit uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .sys_req(sys_req), .brk_req(brk_req),
        .exc_pc(exc_pc), .in_delay(in_delay), .rfe(rfe), .exc_taken(exc_taken),
        .epc(epc), .vector_addr(vector_addr)
    );

    function automatic logic [31:0] push_f(input logic [31:0] s);
        return {s[31:6], s[3:0], 2'b00};
    endfunction
    function automatic logic [31:0] pop_f(input logic [31:0] s);
        return {s[31:4], s[5:2]};
    endfunction
    function automatic logic [31:0] vec_f(input logic [31:0] s);
        return s[22] ? 32'hBFC0_0180 : 32'h8000_0080;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd_chk(input logic [4:0] idx, input logic [31:0] exp, input string tag);
        rd_idx = idx;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [4:0] idx, input logic [31:0] d);
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic exc(input logic s, input logic b, input logic [31:0] pc, input logic d);
        sys_req = s; brk_req = b; exc_pc = pc; in_delay = d;
        tick();
        sys_req = 1'b0; brk_req = 1'b0; in_delay = 1'b0;
    endtask

    task automatic model_entry(input logic [4:0] code, input logic [31:0] pc, input logic d);
        m_st  = push_f(m_st);
        m_ca  = {d, m_ca[30:7], code, m_ca[1:0]};
        m_epc = d ? pc - 32'd4 : pc;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 32; i++) rd_chk(5'(i), 32'h0, "R1 reset slot");
        chk("R1 taken at reset", {31'b0, exc_taken}, 32'h0);
        chk("R1 vector at reset", vector_addr, 32'h8000_0080);

        // R2: plain storage on every non-Cause index
        for (int i = 0; i < 32; i++) begin
            if (i != 13) begin
                m_reg[i] = 32'h1357_9BDF ^ (32'(i) * 32'h0101_0101);
                wr(5'(i), m_reg[i]);
                rd_chk(5'(i), m_reg[i], "R2 plain write");
            end
        end
        wr(5'd12, 32'h0);
        m_st = 32'h0;

        // R3: only Cause bits 9..8 are writable
        wr(5'd13, 32'hFFFF_FFFF);
        rd_chk(5'd13, 32'h0000_0300, "R3 cause write ones");
        wr(5'd13, 32'h0);
        rd_chk(5'd13, 32'h0, "R3 cause write zeros");
        m_ca = 32'h0;

        // R4 R5 R6 R10: entry sweep over all stack states
        for (int s = 0; s < 64; s++) begin
            logic [31:0] st, pc;
            logic use_sys, dly;
            st = 32'h1230_0000 | (32'(s[1]) << 22) | 32'(s);
            wr(5'd12, st);
            m_st = st;
            use_sys = s[3] ^ s[0];
            dly = s[2];
            pc = 32'h0000_4000 + 32'(s) * 32'd16;
            exc(use_sys, !use_sys, pc, dly);
            chk("R4 taken pulse high", {31'b0, exc_taken}, 32'h1);
            model_entry(use_sys ? 5'd8 : 5'd9, pc, dly);
            rd_chk(5'd12, m_st, "R5 status push");
            rd_chk(5'd13, m_ca, "R4 R6 cause code and delay bit");
            chk("R6 epc", epc, m_epc);
            chk("R10 vector select", vector_addr, vec_f(m_st));
            tick();
            chk("R4 taken pulse single", {31'b0, exc_taken}, 32'h0);
        end

        // R7: pop sweep
        for (int s = 0; s < 64; s++) begin
            logic [31:0] st;
            st = 32'h0F00_0000 | 32'(s);
            wr(5'd12, st);
            rfe = 1'b1;
            tick();
            rfe = 1'b0;
            m_st = pop_f(st);
            rd_chk(5'd12, m_st, "R7 status pop");
        end

        // R8: software interrupt sweep over enable, mask and request bits
        for (int s0 = 0; s0 < 2; s0++) begin
            for (int c = 0; c < 4; c++) begin
                for (int m = 0; m < 4; m++) begin
                    logic fire;
                    logic [31:0] pc;
                    pc = 32'h0000_8000 + 32'(c * 16 + m * 4);
                    exc_pc = pc;
                    wr(5'd13, 32'h0);
                    m_ca[9:8] = 2'b00;
                    m_st = (32'(m) << 8) | 32'h14 | 32'(s0);
                    wr(5'd12, m_st);
                    wr(5'd13, 32'(c) << 8);
                    m_ca[9:8] = 2'(c);
                    fire = (s0 == 1) && ((c & m) != 0);
                    tick();
                    chk("R8 swi taken", {31'b0, exc_taken}, {31'b0, fire});
                    if (fire) model_entry(5'd0, pc, 1'b0);
                    rd_chk(5'd12, m_st, "R8 status after swi");
                    rd_chk(5'd13, m_ca, "R8 cause after swi");
                    rd_chk(5'd14, m_epc, "R8 epc after swi");
                    tick();
                    chk("R8 swi not repeated", {31'b0, exc_taken}, 32'h0);
                end
            end
        end

        // R9: system call beats breakpoint
        wr(5'd13, 32'h0);
        m_ca[9:8] = 2'b00;
        wr(5'd12, 32'h0);
        m_st = 32'h0;
        exc(1'b1, 1'b1, 32'h0000_A000, 1'b0);
        model_entry(5'd8, 32'h0000_A000, 1'b0);
        rd_chk(5'd13, m_ca, "R9 sys over brk");

        // R9: breakpoint beats a pending software interrupt
        wr(5'd12, 32'h0000_0301);
        m_st = 32'h0000_0301;
        wr(5'd13, 32'h0000_0300);
        m_ca[9:8] = 2'b11;
        exc(1'b0, 1'b1, 32'h0000_B000, 1'b1);
        model_entry(5'd9, 32'h0000_B000, 1'b1);
        rd_chk(5'd13, m_ca, "R9 brk over swi");
        rd_chk(5'd14, m_epc, "R9 epc brk in delay");

        // R9: write discarded during entry
        wr_en = 1'b1; wr_idx = 5'd5; wr_data = 32'hDEAD_BEEF;
        exc(1'b1, 1'b0, 32'h0000_C000, 1'b0);
        wr_en = 1'b0;
        model_entry(5'd8, 32'h0000_C000, 1'b0);
        rd_chk(5'd5, m_reg[5], "R9 write dropped on entry");

        // R9: pop discarded during entry
        wr(5'd12, 32'h0000_002D);
        m_st = 32'h0000_002D;
        rfe = 1'b1;
        exc(1'b1, 1'b0, 32'h0000_D000, 1'b0);
        rfe = 1'b0;
        model_entry(5'd8, 32'h0000_D000, 1'b0);
        rd_chk(5'd12, m_st, "R9 pop dropped on entry");

        // R11: Status write beats pop
        wr(5'd12, 32'h0000_0015);
        rfe = 1'b1;
        wr(5'd12, 32'h0000_0008);
        rfe = 1'b0;
        rd_chk(5'd12, 32'h0000_0008, "R11 write over pop");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #1ms;
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule